// File: doc/BRIEF.md
# Load-Linked Reservation Unit

This block carries out the load-linked step of an atomic read-modify-write sequence on a 64-bit core. The pipeline presents a virtual address with a one-cycle start strobe. Alongside it come a size select (32-bit word or 64-bit doubleword), a debug-mode flag and the physical address that an external translator has already produced for that virtual address. The block first checks the natural alignment of the access. A misaligned access produces a one-cycle address-error-on-load pulse. Outside debug mode the faulting virtual address is also captured in a bad-address register.

An aligned access issues exactly one memory read over a valid/ready request channel and waits for a response strobe. When the response arrives, the block stores the reservation: the physical link address, the virtual link address, the loaded value and a link-valid flag. A word result is sign-extended from bit 31 before it is stored. One cycle after the response the block raises a done pulse and presents the same value as the instruction result for the register file. A later store-conditional stage, which lies outside this block, compares against the reservation outputs.

Top module: `ll_reserve_unit`

## Requirements
- R1: A word access (`dword_i`=0) whose `vaddr_i[1:0]` is nonzero raises `addr_err_o` for exactly the one cycle after the start edge and issues no memory request.
- R2: A doubleword access (`dword_i`=1) is misaligned when `vaddr_i[2:0]` is nonzero; a word access with only bit 2 set is aligned.
- R3: On a misaligned access with `dbg_mode_i`=0, `badvaddr_o` takes `vaddr_i` from the cycle after the start edge. With `dbg_mode_i`=1, `badvaddr_o` keeps its previous value.
- R4: A misaligned access leaves `link_paddr_o`, `link_vaddr_o`, `link_value_o` and `link_valid_o` unchanged.
- R5: An aligned access drives `mem_req_o`=1 with `mem_addr_o` equal to `paddr_i` from the cycle after the start edge. Both hold until a cycle in which `mem_ready_i`=1, and `mem_req_o` drops after that cycle.
- R6: `done_o` is a one-cycle pulse in the cycle after the edge at which `mem_rsp_valid_i`=1 is accepted, and `result_o` holds the loaded value in that cycle.
- R7: On completion, `link_paddr_o` and `link_vaddr_o` hold the physical and virtual addresses of that access.
- R8: A word result is `mem_rsp_data_i[31:0]` sign-extended from bit 31, ignoring bits 63:32. A doubleword result is `mem_rsp_data_i` unchanged. `link_value_o` equals `result_o`.
- R9: `link_valid_o` is 0 after reset and is 1 from the cycle after the first completed load-linked access.
- R10: A start strobe that arrives while an access is in progress is ignored: it raises no error, updates no bad address and changes no request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for one load-linked access |
| dword_i | input | 1 | Size select: 1 = doubleword, 0 = word |
| dbg_mode_i | input | 1 | Debug mode; suppresses the bad-address capture |
| vaddr_i | input | XLEN (64) | Virtual address of the access |
| paddr_i | input | PA_W (40) | Translated physical address of `vaddr_i` |
| mem_req_o | output | 1 | Memory read request valid |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | PA_W (40) | Memory read address |
| mem_rsp_valid_i | input | 1 | Read data valid strobe |
| mem_rsp_data_i | input | XLEN (64) | Read data, right-aligned |
| done_o | output | 1 | Access complete pulse |
| result_o | output | XLEN (64) | Value for the register file |
| addr_err_o | output | 1 | Address-error-on-load pulse |
| badvaddr_o | output | XLEN (64) | Last captured faulting virtual address |
| link_paddr_o | output | PA_W (40) | Reserved physical address |
| link_vaddr_o | output | XLEN (64) | Reserved virtual address |
| link_value_o | output | XLEN (64) | Reserved loaded value |
| link_valid_o | output | 1 | Reservation has been set |

## Verification
The error pulse and the bad-address update are due one cycle after the start edge. The first memory request is also due in that cycle. The done pulse, the result and all reservation outputs are due one cycle after the edge that accepts the response. The bench drives every input on the falling edge. It samples each of these results on the falling edge after the rising edge that produces it. One further falling edge later it confirms that the error and done pulses have dropped and that the request has ended. Ready and response latencies vary across the vectors. This confirms that the request holds while ready is low and that the timing does not depend on the delays.

// File: rtl/ll_pkg.sv
package ll_pkg;
   typedef enum logic [1:0] {
      LL_IDLE = 2'd0,
      LL_REQ  = 2'd1,
      LL_WAIT = 2'd2,
      LL_DONE = 2'd3
   } ll_state_e;
endpackage

// File: rtl/ll_align_chk.sv
module ll_align_chk #(
   parameter int XLEN   = 64,
   parameter int WORD_W = 32,
   localparam int W_LSB = $clog2(WORD_W / 8),
   localparam int D_LSB = $clog2(XLEN / 8)
) (
   input  logic [D_LSB-1:0] low_i,
   input  logic             dword_i,
   output logic             misaligned_o
);
   initial begin : p_param_chk
      assert (D_LSB > W_LSB && W_LSB > 0)
         else $fatal(1, "ll_align_chk: doubleword must be wider than word");
   end

   always_comb begin
      if (dword_i) misaligned_o = |low_i;
      else         misaligned_o = |low_i[W_LSB-1:0];
   end
endmodule

// File: rtl/ll_sext.sv
module ll_sext #(
   parameter int XLEN   = 64,
   parameter int WORD_W = 32
) (
   input  logic [XLEN-1:0] data_i,
   input  logic            dword_i,
   output logic [XLEN-1:0] data_o
);
   initial begin : p_param_chk
      assert (XLEN > WORD_W)
         else $fatal(1, "ll_sext: XLEN must exceed WORD_W");
   end

   for (genvar i = 0; i < XLEN; i++) begin : g_bit
      if (i < WORD_W) begin : g_low
         assign data_o[i] = data_i[i];
      end else begin : g_high
         assign data_o[i] = dword_i ? data_i[i] : data_i[WORD_W-1];
      end
   end
endmodule

// File: rtl/ll_reserve_unit.sv
module ll_reserve_unit
   import ll_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int WORD_W = 32,
   parameter int PA_W   = 40
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            dword_i,
   input  logic            dbg_mode_i,
   input  logic [XLEN-1:0] vaddr_i,
   input  logic [PA_W-1:0] paddr_i,
   output logic            mem_req_o,
   input  logic            mem_ready_i,
   output logic [PA_W-1:0] mem_addr_o,
   input  logic            mem_rsp_valid_i,
   input  logic [XLEN-1:0] mem_rsp_data_i,
   output logic            done_o,
   output logic [XLEN-1:0] result_o,
   output logic            addr_err_o,
   output logic [XLEN-1:0] badvaddr_o,
   output logic [PA_W-1:0] link_paddr_o,
   output logic [XLEN-1:0] link_vaddr_o,
   output logic [XLEN-1:0] link_value_o,
   output logic            link_valid_o
);
   localparam int D_LSB = $clog2(XLEN / 8);

   initial begin : p_param_chk
      assert (XLEN == 2 * WORD_W)
         else $fatal(1, "ll_reserve_unit: XLEN must be twice WORD_W");
      assert (PA_W > D_LSB && PA_W <= XLEN)
         else $fatal(1, "ll_reserve_unit: PA_W out of range");
   end

   ll_state_e       state_q;
   logic            op_dw_q;
   logic [XLEN-1:0] op_va_q;
   logic [PA_W-1:0] op_pa_q;
   logic            err_q;
   logic [XLEN-1:0] badva_q;
   logic [PA_W-1:0] lpa_q;
   logic [XLEN-1:0] lva_q;
   logic [XLEN-1:0] lval_q;
   logic            lvalid_q;
   logic            misaligned;
   logic [XLEN-1:0] ext_data;

   ll_align_chk #(.XLEN(XLEN), .WORD_W(WORD_W)) u_align (
      .low_i        (vaddr_i[D_LSB-1:0]),
      .dword_i      (dword_i),
      .misaligned_o (misaligned)
   );

   ll_sext #(.XLEN(XLEN), .WORD_W(WORD_W)) u_sext (
      .data_i  (mem_rsp_data_i),
      .dword_i (op_dw_q),
      .data_o  (ext_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= LL_IDLE;
         op_dw_q  <= 1'b0;
         op_va_q  <= '0;
         op_pa_q  <= '0;
         err_q    <= 1'b0;
         badva_q  <= '0;
         lpa_q    <= '0;
         lva_q    <= '0;
         lval_q   <= '0;
         lvalid_q <= 1'b0;
      end else begin
         err_q <= 1'b0;
         unique case (state_q)
            LL_IDLE: begin
               if (start_i) begin
                  if (misaligned) begin
                     err_q <= 1'b1;
                     if (!dbg_mode_i) badva_q <= vaddr_i;
                  end else begin
                     op_dw_q <= dword_i;
                     op_va_q <= vaddr_i;
                     op_pa_q <= paddr_i;
                     state_q <= LL_REQ;
                  end
               end
            end
            LL_REQ: begin
               if (mem_ready_i) state_q <= LL_WAIT;
            end
            LL_WAIT: begin
               if (mem_rsp_valid_i) begin
                  lval_q   <= ext_data;
                  lpa_q    <= op_pa_q;
                  lva_q    <= op_va_q;
                  lvalid_q <= 1'b1;
                  state_q  <= LL_DONE;
               end
            end
            LL_DONE: state_q <= LL_IDLE;
            default: state_q <= LL_IDLE;
         endcase
      end
   end

   assign mem_req_o    = (state_q == LL_REQ);
   assign mem_addr_o   = op_pa_q;
   assign done_o       = (state_q == LL_DONE);
   assign result_o     = lval_q;
   assign addr_err_o   = err_q;
   assign badvaddr_o   = badva_q;
   assign link_paddr_o = lpa_q;
   assign link_vaddr_o = lva_q;
   assign link_value_o = lval_q;
   assign link_valid_o = lvalid_q;

   // R1: an error cycle never carries a memory request
   a_r1_err_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err_o |-> !mem_req_o);

   // R1: the error is a single-cycle pulse
   a_r1_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err_o |=> !addr_err_o);

   // R4: reservation untouched in the error cycle
   a_r4_link_kept: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err_o |-> ($stable(link_paddr_o) && $stable(link_vaddr_o)
                      && $stable(link_value_o) && $stable(link_valid_o)));

   // R5: request and address hold while not accepted
   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

   // R5: request drops after acceptance
   a_r5_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_ready_i) |=> !mem_req_o);

   // R6: done follows an accepted response by one cycle
   a_r6_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LL_WAIT && mem_rsp_valid_i) |=> done_o);

   // R6: done is a single-cycle pulse
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9: once set, the link flag stays set
   a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      link_valid_o |=> link_valid_o);
endmodule

// File: tb/tb_ll_reserve_unit.sv
module tb_ll_reserve_unit;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN = 64;
   localparam int PA_W = 40;
   localparam int NVEC = 8;

   localparam logic [NVEC-1:0] V_DW  = 8'b0101_0100;
   localparam logic [NVEC-1:0] V_DBG = 8'b0010_0000;
   localparam logic [XLEN-1:0] V_VA [NVEC] = '{
      64'h0000_0000_1000_0000, 64'h0000_0000_1000_1004,
      64'h0000_0000_1000_1008, 64'h0000_0000_1000_1001,
      64'h0000_0000_1000_2004, 64'h0000_0000_1000_2002,
      64'h0000_0000_1000_3003, 64'hFFFF_FFFF_FFFF_FFF0};
   localparam logic [XLEN-1:0] V_RD [NVEC] = '{
      64'hDEAD_BEEF_8000_0001, 64'hFFFF_FFFF_1234_5678,
      64'h8123_4567_89AB_CDEF, 64'h0,
      64'h0, 64'h0, 64'h0,
      64'hAAAA_AAAA_7FFF_FFFF};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0, dword_i = 1'b0, dbg_mode_i = 1'b0;
   logic [XLEN-1:0] vaddr_i = '0;
   logic [PA_W-1:0] paddr_i = '0;
   logic            mem_ready_i = 1'b0, mem_rsp_valid_i = 1'b0;
   logic [XLEN-1:0] mem_rsp_data_i = '0;
   logic            mem_req_o, done_o, addr_err_o, link_valid_o;
   logic [PA_W-1:0] mem_addr_o, link_paddr_o;
   logic [XLEN-1:0] result_o, badvaddr_o, link_vaddr_o, link_value_o;

   int total = 0;
   int bad = 0;
   logic [XLEN-1:0] exp_bad = '0;
   logic [PA_W-1:0] exp_lpa = '0;
   logic [XLEN-1:0] exp_lva = '0, exp_lval = '0;
   logic            exp_lvalid = 1'b0;

   ll_reserve_unit dut (.*);

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [PA_W-1:0] xlate(input logic [XLEN-1:0] va);
      return va[PA_W-1:0] ^ 40'h55_0000_0000;
   endfunction

   task automatic check_link(input string tag);
      chk({tag, " R7 link_paddr"}, XLEN'(link_paddr_o), XLEN'(exp_lpa));
      chk({tag, " R7 link_vaddr"}, link_vaddr_o, exp_lva);
      chk({tag, " R8 link_value"}, link_value_o, exp_lval);
      chk({tag, " R9 link_valid"}, XLEN'(link_valid_o), XLEN'(exp_lvalid));
   endtask

   task automatic run_op(input logic dw, input logic dbg, input logic [XLEN-1:0] va,
                         input logic [XLEN-1:0] rd, input int rdy_dly, input int rsp_dly);
      logic mis;
      logic [XLEN-1:0] res;
      mis = dw ? (va[2:0] != 0) : (va[1:0] != 0);
      res = dw ? rd : {{32{rd[31]}}, rd[31:0]};
      @(negedge clk);
      start_i = 1'b1; dword_i = dw; dbg_mode_i = dbg; vaddr_i = va; paddr_i = xlate(va);
      @(negedge clk);
      start_i = 1'b0;
      if (mis) begin
         if (!dbg) exp_bad = va;
         chk("R1 R2 addr_err pulse", XLEN'(addr_err_o), 1);
         chk("R1 no request on error", XLEN'(mem_req_o), 0);
         chk("R3 badvaddr", badvaddr_o, exp_bad);
         check_link("R4");
         @(negedge clk);
         chk("R1 addr_err drops", XLEN'(addr_err_o), 0);
      end else begin
         chk("R2 no error on aligned", XLEN'(addr_err_o), 0);
         chk("R5 request up", XLEN'(mem_req_o), 1);
         chk("R5 request addr", XLEN'(mem_addr_o), XLEN'(xlate(va)));
         for (int k = 0; k < rdy_dly; k++) begin
            @(negedge clk);
            chk("R5 request held", XLEN'(mem_req_o), 1);
         end
         mem_ready_i = 1'b1;
         @(negedge clk);
         mem_ready_i = 1'b0;
         chk("R5 request dropped", XLEN'(mem_req_o), 0);
         for (int k = 0; k < rsp_dly; k++) @(negedge clk);
         mem_rsp_valid_i = 1'b1; mem_rsp_data_i = rd;
         @(negedge clk);
         mem_rsp_valid_i = 1'b0; mem_rsp_data_i = '0;
         exp_lpa = xlate(va); exp_lva = va; exp_lval = res; exp_lvalid = 1'b1;
         chk("R6 done pulse", XLEN'(done_o), 1);
         chk("R8 result", result_o, res);
         check_link("R7");
         @(negedge clk);
         chk("R6 done drops", XLEN'(done_o), 0);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk("R9 reset link_valid", XLEN'(link_valid_o), 0);
      chk("reset mem_req", XLEN'(mem_req_o), 0);
      chk("reset done", XLEN'(done_o), 0);
      chk("reset badvaddr", badvaddr_o, 0);
      rst_n = 1'b1;
      for (int i = 0; i < NVEC; i++)
         run_op(V_DW[i], V_DBG[i], V_VA[i], V_RD[i], i % 3, i % 2);

      // R10: a misaligned start during an active access is ignored
      @(negedge clk);
      start_i = 1'b1; dword_i = 1'b0; dbg_mode_i = 1'b0;
      vaddr_i = 64'h0000_0000_2000_0000; paddr_i = xlate(vaddr_i);
      @(negedge clk);
      vaddr_i = 64'h0000_0000_3000_0001; paddr_i = 40'h12_3456_7890;
      @(negedge clk);
      start_i = 1'b0;
      chk("R10 no error while busy", XLEN'(addr_err_o), 0);
      chk("R10 badvaddr kept", badvaddr_o, exp_bad);
      chk("R10 request addr kept", XLEN'(mem_addr_o), XLEN'(xlate(64'h0000_0000_2000_0000)));
      mem_ready_i = 1'b1;
      @(negedge clk);
      mem_ready_i = 1'b0;
      mem_rsp_valid_i = 1'b1; mem_rsp_data_i = 64'h0000_0001_FFFF_FFFE;
      @(negedge clk);
      mem_rsp_valid_i = 1'b0;
      chk("R8 word negative", result_o, 64'hFFFF_FFFF_FFFF_FFFE);
      chk("R7 link_vaddr after busy start", link_vaddr_o, 64'h0000_0000_2000_0000);
      @(negedge clk);
      chk("R10 no late error", XLEN'(addr_err_o), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule